// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block sends a continuous serial bit stream that a host supplies one byte at a time. It holds two byte-wide shift registers and uses them in turn. While one register drives the serial output, the other takes the next byte from the host. Bits leave most significant bit first, one bit for each pulse on a slow bit-rate strobe. In the intended use that strobe is a 200 Hz enable derived from the system clock. When the working register empties and the other one holds a byte, the roles change hands. The next bit strobe then sends the first bit of the new byte, so no bit period is lost.

Each time a byte has been sent in full, a sticky word-done flag is set and the interrupt line rises with it. Two further sticky status bits report errors. Underrun means a bit strobe arrived while no byte was waiting. Overrun means the host offered a byte while both registers were occupied. A single clear pulse drops all three flags.

Bytes enter through a valid/ready port. The block raises `wr_ready` while at least one register is free, and a byte is taken on any cycle in which `wr_valid` and `wr_ready` are both high. The host is not stalled. A byte offered while `wr_ready` is low is discarded, not held, and the overrun bit records the loss. The host should therefore wait for `wr_ready` or the interrupt before it offers the next byte.

Top module: `tx_pingpong`

## Requirements
- R1: After reset `tx_out` is 0, `wr_ready` is 1, and `word_done`, `irq`, `underrun` and `overrun` are all 0.
- R2: `wr_ready` is 1 exactly when fewer than two bytes are held (a byte counts as held until its last bit has been sent). A byte is accepted on a cycle with `wr_valid` and `wr_ready` both high.
- R3: Bytes are sent in the order they were accepted, most significant bit first. On each `bit_tick` cycle with a byte held, the next bit appears on `tx_out` in the following cycle. Without `bit_tick`, `tx_out` does not change.
- R4: When a byte's eighth bit has been sent and another byte is held, the next `bit_tick` sends that byte's most significant bit, with no idle bit period between them.
- R5: The cycle after the `bit_tick` that sends a byte's eighth bit, `word_done` and `irq` are 1.
- R6: `word_done`, `irq`, `underrun` and `overrun` stay set until a `flag_clr` cycle, which clears them in the next cycle. A set condition in the same cycle as `flag_clr` wins.
- R7: A `bit_tick` while no byte is held leaves `tx_out` at its previous level and sets `underrun` in the next cycle.
- R8: A cycle with `wr_valid` high and `wr_ready` low discards the offered byte, so it is never sent, and sets `overrun` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered by the host |
| wr_ready | output | 1 | A register is free to take a byte |
| bit_tick | input | 1 | Single-cycle bit-rate strobe |
| flag_clr | input | 1 | Clears the done, underrun and overrun flags |
| tx_out | output | 1 | Serial output, registered |
| word_done | output | 1 | Sticky flag: a byte has been sent in full |
| irq | output | 1 | Interrupt request, follows `word_done` |
| underrun | output | 1 | Sticky flag: a bit strobe found no data |
| overrun | output | 1 | Sticky flag: an offered byte was dropped |

## Verification
The assertions assume that `bit_tick` is a clean single-cycle pulse that comes no faster than once every two clock cycles. They also assume that `flag_clr` and `wr_valid` are synchronous to `clk`. The stimulus respects these assumptions by spacing strobes with a random gap of two or more cycles. It also drives inputs only on the falling edge. Within those limits, the stimulus offers bytes at random, often while both registers are full, so the overrun path is exercised. It also lets strobes run with nothing queued, which exercises underrun.

// File: rtl/tx_pingpong_pkg.sv
package tx_pingpong_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_SLOTS = 2;

  typedef struct packed {
    logic done;
    logic under;
    logic over;
  } tx_flags_t;
endpackage

// File: rtl/tx_pp_slot.sv
module tx_pp_slot #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             shift,
  output logic             full,
  output logic             head_bit,
  output logic             last_bit
);
  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  logic [WIDTH-1:0] sreg;
  logic [CNT_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      bit_idx <= '0;
      full    <= 1'b0;
    end else if (load) begin
      sreg    <= load_data;
      bit_idx <= '0;
      full    <= 1'b1;
    end else if (shift && full) begin
      sreg    <= {sreg[WIDTH-2:0], 1'b0};
      bit_idx <= bit_idx + 1'b1;
      if (bit_idx == LAST_IDX) full <= 1'b0;
    end
  end

  assign head_bit = sreg[WIDTH-1];
  assign last_bit = (bit_idx == LAST_IDX);
endmodule

// File: rtl/tx_pp_ctrl.sv
module tx_pp_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] slot_full,
  input  logic [1:0] slot_last,
  input  logic       wr_valid,
  input  logic       bit_tick,
  output logic       wr_sel,
  output logic       act_sel,
  output logic       accept,
  output logic       shift_act,
  output logic       byte_end,
  output logic       starved,
  output logic       dropped
);
  logic free_slot;

  assign free_slot = !slot_full[wr_sel];
  assign accept    = wr_valid && free_slot;
  assign dropped   = wr_valid && !free_slot;
  assign shift_act = bit_tick && slot_full[act_sel];
  assign starved   = bit_tick && !slot_full[act_sel];
  assign byte_end  = shift_act && slot_last[act_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sel  <= 1'b0;
      act_sel <= 1'b0;
    end else begin
      if (accept)   wr_sel  <= ~wr_sel;
      if (byte_end) act_sel <= ~act_sel;
    end
  end
endmodule

// File: rtl/tx_pp_status.sv
module tx_pp_status
  import tx_pingpong_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  tx_flags_t set_ev,
  output tx_flags_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.done  <= set_ev.done  | (flags.done  & ~clr);
      flags.under <= set_ev.under | (flags.under & ~clr);
      flags.over  <= set_ev.over  | (flags.over  & ~clr);
    end
  end
endmodule

// File: rtl/tx_pingpong.sv
module tx_pingpong
  import tx_pingpong_pkg::*;
#(
  parameter int unsigned WIDTH = BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  input  logic             bit_tick,
  input  logic             flag_clr,
  output logic             tx_out,
  output logic             word_done,
  output logic             irq,
  output logic             underrun,
  output logic             overrun
);
  logic [1:0] slot_full, slot_last, slot_head, slot_load, slot_shift;
  logic       wr_sel, act_sel, accept, shift_act, byte_end, starved, dropped;
  tx_flags_t  set_ev, flags;

  tx_pp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_full(slot_full), .slot_last(slot_last),
    .wr_valid(wr_valid), .bit_tick(bit_tick), .wr_sel(wr_sel), .act_sel(act_sel),
    .accept(accept), .shift_act(shift_act), .byte_end(byte_end),
    .starved(starved), .dropped(dropped)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_load[s]  = accept && (wr_sel == 1'(s));
    assign slot_shift[s] = shift_act && (act_sel == 1'(s));
    tx_pp_slot #(.WIDTH(WIDTH)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(slot_load[s]), .load_data(wr_data),
      .shift(slot_shift[s]), .full(slot_full[s]), .head_bit(slot_head[s]),
      .last_bit(slot_last[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_out <= 1'b0;
    else if (shift_act) tx_out <= slot_head[act_sel];
  end

  assign set_ev.done  = byte_end;
  assign set_ev.under = starved;
  assign set_ev.over  = dropped;

  tx_pp_status u_status (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr), .set_ev(set_ev), .flags(flags)
  );

  assign wr_ready  = !slot_full[wr_sel];
  assign word_done = flags.done;
  assign irq       = flags.done;
  assign underrun  = flags.under;
  assign overrun   = flags.over;
endmodule

// File: rtl/tx_pingpong_chk.sv
module tx_pingpong_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       bit_tick,
  input logic       flag_clr,
  input logic       tx_out,
  input logic       word_done,
  input logic       underrun,
  input logic       overrun,
  input logic [1:0] slot_full
);
  // R2: the port is ready whenever at least one register is free
  a_r2_ready_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == !(&slot_full));

  // R3: the output moves only on a bit strobe
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_out));

  // R6: the done flag stays set without a clear
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !flag_clr |=> word_done);

  // R7: a strobe with nothing held keeps the level and reports underrun
  a_r7_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && (slot_full == 2'b00) |=> underrun && $stable(tx_out));

  // R8: an offer while not ready is reported as overrun
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> overrun);
endmodule

bind tx_pingpong tx_pingpong_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .bit_tick(bit_tick), .flag_clr(flag_clr), .tx_out(tx_out),
  .word_done(word_done), .underrun(underrun), .overrun(overrun),
  .slot_full(slot_full)
);

// File: tb/tx_pingpong_bench.sv
`timescale 1ns/1ps
module tx_pingpong_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       bit_tick = 1'b0;
  logic       flag_clr = 1'b0;
  logic       wr_ready, tx_out, word_done, irq, underrun, overrun;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;

  // reference model: an ordered queue of held bytes
  logic [7:0] m_q [0:1];
  int         m_cnt = 0;
  int         m_idx = 0;
  logic       m_tx = 1'b0, m_done = 1'b0, m_under = 1'b0, m_over = 1'b0;
  int         tick_gap = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  tx_pingpong u_tx_pingpong (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .bit_tick(bit_tick), .flag_clr(flag_clr),
    .tx_out(tx_out), .word_done(word_done), .irq(irq),
    .underrun(underrun), .overrun(overrun)
  );

  function automatic logic exp_ready(int cnt);
    return cnt < 2;
  endfunction

  function automatic logic exp_bit(logic [7:0] b, int idx);
    return b[7-idx];
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    check({"R2 ready ", tag}, wr_ready, exp_ready(m_cnt));
    check({"R3/R4/R7 tx_out ", tag}, tx_out, m_tx);
    check({"R5 word_done ", tag}, word_done, m_done);
    check({"R5 irq ", tag}, irq, m_done);
    check({"R7 underrun ", tag}, underrun, m_under);
    check({"R8 overrun ", tag}, overrun, m_over);
  endtask

  // apply inputs at the falling edge, then advance the model across the rising edge
  task automatic step(logic v, logic [7:0] d, logic t, logic c);
    logic rdy, fin;
    wr_valid = v; wr_data = d; bit_tick = t; flag_clr = c;
    rdy = exp_ready(m_cnt);
    fin = 1'b0;
    if (c) begin m_done = 1'b0; m_under = 1'b0; m_over = 1'b0; end
    if (t) begin
      if (m_cnt > 0) begin
        m_tx = exp_bit(m_q[0], m_idx);
        m_idx++;
        if (m_idx == 8) begin fin = 1'b1; m_idx = 0; m_done = 1'b1; end
      end else begin
        m_under = 1'b1;
      end
    end
    if (v && !rdy) m_over = 1'b1;
    if (fin) begin m_q[0] = m_q[1]; m_cnt--; end
    if (v && rdy) begin m_q[m_cnt] = d; m_cnt++; end
    @(negedge clk);
    check_all("step");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_out", tx_out, 1'b0);
    check("R1 wr_ready", wr_ready, 1'b1);
    check("R1 word_done", word_done, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 underrun", underrun, 1'b0);
    check("R1 overrun", overrun, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: strobe with nothing queued
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);
    // R6: clear drops the flags
    step(0, 8'h00, 0, 1);
    // R2/R8: fill both, then offer a third that must be dropped
    step(1, 8'hA5, 0, 0);
    step(1, 8'h3C, 0, 0);
    step(1, 8'hFF, 0, 0);
    step(0, 8'h00, 0, 0);
    // R3/R4/R5: send both bytes back to back
    for (int i = 0; i < 16; i++) begin
      step(0, 8'h00, 1, 0);
      step(0, 8'h00, 0, 0);
    end
    // R6: set wins over clear on the same cycle
    step(1, 8'h81, 0, 1);
    for (int i = 0; i < 7; i++) begin
      step(0, 8'h00, 1, 0);
      step(0, 8'h00, 0, 0);
    end
    step(0, 8'h00, 1, 1);
    step(0, 8'h00, 0, 0);

    // constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      logic v, t, c;
      v = ($urandom_range(0, 3) == 0);
      c = ($urandom_range(0, 19) == 0);
      t = 1'b0;
      if (tick_gap == 0) begin
        t = 1'b1;
        tick_gap = $urandom_range(1, 6);
      end else begin
        tick_gap--;
      end
      step(v, 8'($urandom), t, c);
      if (t) tick_gap = (tick_gap < 1) ? 1 : tick_gap;
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule